// File: doc/BRIEF.md
# Event Counter Bank with Set/Clear Control

This block holds a small bank of 32-bit event counters and one 64-bit free-running cycle counter, the kind of counting resource a cache performance monitor provides. Software reaches every piece of state through a single-cycle register write port and a combinational read port. Each general counter advances on its own event strobe. The cycle counter advances on every clock. A counter only moves while its own enable bit and the global enable are both on.

Counter enable, interrupt enable and overflow status are three 32-bit masks. Software changes them only through write-one-to-set and write-one-to-clear register pairs. General counter i owns bit i of each mask. The cycle counter owns bit `CYC_BIT` (31 by default) rather than bit N. When a counter wraps from all-ones to zero it flags overflow. A level interrupt stays high while any overflow bit is set together with its interrupt-enable bit. The cycle counter is visible as separate low and high words, so software reads it coherently with a high, low, high sequence and retries if the two high reads differ.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, the enable mask, the interrupt-enable mask, the overflow mask and the global enable are zero, and `irq` is low.
- R2: Register 0x000 (control) reads the number of general counters in bits 15:11 and the global enable in bit 0. All its other bits read zero.
- R3: Each mask has a set register and a clear register: enable at 0x010/0x014, interrupt enable at 0x018/0x01C, overflow at 0x020/0x024. Writing 1 to a bit of the set register sets it and writing 1 to a bit of the clear register clears it. Zero bits and bits mapped to no counter are ignored. Both registers of a pair read back the current mask.
- R4: General counter i maps to mask bit i, and the cycle counter maps to mask bit 31.
- R5: A general counter increments by one in each cycle its strobe is high while its enable bit and the global enable are set. Otherwise it holds.
- R6: The cycle counter increments on every clock while mask bit 31 and the global enable are set.
- R7: General counter i is read and loaded at 0x100 + 16*i. A write loads the value in the next cycle, and a load beats a strobe in the same cycle.
- R8: The cycle counter's low word is at 0x030 and its high word is at 0x034. Each word loads independently, and a load beats the increment.
- R9: A counter that increments from all-ones becomes zero and sets its overflow bit. A wrap beats an overflow clear in the same cycle.
- R10: `irq` is high exactly while some overflow bit and its interrupt-enable bit are both set.
- R11: Writing control with bit 1 set zeroes every counter, beating loads and increments. It leaves the masks unchanged. Bit 1 always reads zero.
- R12: A control write sets the global enable from bit 0. While the global enable is off, no counter changes except by a load or a reset-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_strobe | input | NUM_EV | Per-counter event strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt on enabled overflow |

## Verification
Directed sequences come first. They check the reset image and mask set/clear with zero and unmapped bits. They count with the global enable off and then on, with one counter disabled, which separates a per-counter gate from the global gate. They load against a simultaneous strobe, wrap a general counter and the 64-bit cycle counter across the word boundary, and issue reset-all while counting. A seeded random phase follows. It mixes strobe patterns with writes to every register, biased toward near-overflow loads, occasional reset-all and clears that collide with wraps. This exposes any wrong priority among load, reset, increment and overflow clear.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_EV  = 4,
  parameter int CYC_BIT = 31,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_strobe,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_EN_S = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_EN_C = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] A_IE_S = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] A_IE_C = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] A_OV_S = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_OV_C = ADDR_W'(12'h024);
  localparam logic [ADDR_W-1:0] A_CY_L = ADDR_W'(12'h030);
  localparam logic [ADDR_W-1:0] A_CY_H = ADDR_W'(12'h034);
  localparam int EV_BASE = 'h100;
  localparam logic [31:0] VALID = ((32'd1 << NUM_EV) - 32'd1) | (32'd1 << CYC_BIT);

  logic        glob_en;
  logic [31:0] cnten, inten, ovf, wrap_vec;
  logic [31:0] ev_cnt [NUM_EV];
  logic [NUM_EV-1:0] ev_wrap;
  logic [63:0] cyc_cnt;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire rst_all = wr_ctrl && reg_wdata[1];
  wire ld_lo   = reg_wr && reg_addr == A_CY_L;
  wire ld_hi   = reg_wr && reg_addr == A_CY_H;
  wire cyc_inc = glob_en && cnten[CYC_BIT];
  wire cyc_wrap = cyc_inc && !ld_lo && !ld_hi && !rst_all && (&cyc_cnt);

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    wire ld  = reg_wr && reg_addr == ADDR_W'(EV_BASE + 16 * g);
    wire inc = glob_en && cnten[g] && ev_strobe[g];
    assign ev_wrap[g] = inc && !ld && !rst_all && (&ev_cnt[g]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       ev_cnt[g] <= '0;
      else if (rst_all) ev_cnt[g] <= '0;
      else if (ld)      ev_cnt[g] <= reg_wdata;
      else if (inc)     ev_cnt[g] <= ev_cnt[g] + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc_cnt <= '0;
    else if (rst_all) cyc_cnt <= '0;
    else if (ld_lo || ld_hi) begin
      if (ld_lo) cyc_cnt[31:0]  <= reg_wdata;
      if (ld_hi) cyc_cnt[63:32] <= reg_wdata;
    end
    else if (cyc_inc) cyc_cnt <= cyc_cnt + 64'd1;

  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_EV-1:0] = ev_wrap;
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  function automatic logic [31:0] pick(input logic [ADDR_W-1:0] a);
    return (reg_wr && reg_addr == a) ? (reg_wdata & VALID) : 32'd0;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      glob_en <= 1'b0;
      cnten   <= '0;
      inten   <= '0;
      ovf     <= '0;
    end else begin
      if (wr_ctrl) glob_en <= reg_wdata[0];
      cnten <= (cnten & ~pick(A_EN_C)) | pick(A_EN_S);
      inten <= (inten & ~pick(A_IE_C)) | pick(A_IE_S);
      ovf   <= (ovf & ~pick(A_OV_C)) | pick(A_OV_S) | wrap_vec;
    end

  assign irq = |(ovf & inten);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[15:11] = 5'(NUM_EV);
        reg_rdata[0]     = glob_en;
      end
      A_EN_S, A_EN_C: reg_rdata = cnten;
      A_IE_S, A_IE_C: reg_rdata = inten;
      A_OV_S, A_OV_C: reg_rdata = ovf;
      A_CY_L:         reg_rdata = cyc_cnt[31:0];
      A_CY_H:         reg_rdata = cyc_cnt[63:32];
      default:
        for (int i = 0; i < NUM_EV; i++)
          if (reg_addr == ADDR_W'(EV_BASE + 16 * i)) reg_rdata = ev_cnt[i];
    endcase
  end

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EN_S) |=>
      ((cnten & $past(reg_wdata & VALID)) == $past(reg_wdata & VALID)));

  // R9
  wrap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && cnten[0] && ev_strobe[0] && ev_cnt[0] == 32'hFFFF_FFFF &&
     !(reg_wr && (reg_addr == A_CTRL || reg_addr == ADDR_W'(EV_BASE))))
      |=> (ovf[0] && ev_cnt[0] == 32'd0));

  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_IE_C && reg_wdata == 32'hFFFF_FFFF) |=> !irq);

  // R11
  rst_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_all |=> (cyc_cnt == 64'd0 && ev_cnt[0] == 32'd0));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !reg_wr) |=> $stable(cyc_cnt));
endmodule

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [3:0] ev_strobe;
  logic reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq;

  perf_counter_bank uut (.clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  localparam logic [31:0] VM = 32'h8000_000F;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_cnt [4];
  logic [63:0] m_cyc;
  logic [31:0] m_en, m_ie, m_ov;
  bit m_glob;

  function automatic logic [31:0] exp_reg(input logic [11:0] a);
    case (a)
      12'h000: return {16'h0, 5'd4, 10'h0, m_glob};
      12'h010, 12'h014: return m_en;
      12'h018, 12'h01C: return m_ie;
      12'h020, 12'h024: return m_ov;
      12'h030: return m_cyc[31:0];
      12'h034: return m_cyc[63:32];
      12'h100: return m_cnt[0];
      12'h110: return m_cnt[1];
      12'h120: return m_cnt[2];
      12'h130: return m_cnt[3];
      default: return 32'h0;
    endcase
  endfunction

  function automatic void mupd(bit w, logic [11:0] a, logic [31:0] d, logic [3:0] s);
    bit ra;
    logic [31:0] wrap, en0;
    ra = w && a == 12'h000 && d[1];
    wrap = '0;
    en0 = m_en;
    for (int i = 0; i < 4; i++) begin
      if (ra) m_cnt[i] = '0;
      else if (w && a == 12'(12'h100 + 16 * i)) m_cnt[i] = d;
      else if (m_glob && en0[i] && s[i]) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wrap[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (ra) m_cyc = '0;
    else if (w && (a == 12'h030 || a == 12'h034)) begin
      if (a == 12'h030) m_cyc[31:0] = d; else m_cyc[63:32] = d;
    end else if (m_glob && en0[31]) begin
      if (&m_cyc) wrap[31] = 1'b1;
      m_cyc = m_cyc + 1;
    end
    if (w)
      case (a)
        12'h000: m_glob = d[0];
        12'h010: m_en = m_en | (d & VM);
        12'h014: m_en = m_en & ~d;
        12'h018: m_ie = m_ie | (d & VM);
        12'h01C: m_ie = m_ie & ~d;
        12'h020: m_ov = m_ov | (d & VM);
        12'h024: m_ov = m_ov & ~d;
        default: ;
      endcase
    m_ov = m_ov | wrap;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input logic [11:0] a, input string tag);
    reg_wr = 1'b0;
    reg_addr = a;
    #0.2;
    chk($sformatf("%s @%h", tag, a), reg_rdata, exp_reg(a));
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, {31'b0, irq}, {31'b0, |(m_ov & m_ie)});
  endtask

  task automatic tick(input bit w, input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    reg_wr = w; reg_addr = a; reg_wdata = d; ev_strobe = s;
    @(posedge clk);
    mupd(w, a, d, s);
    @(negedge clk);
    reg_wr = 1'b0; ev_strobe = '0;
  endtask

  logic [11:0] alist [14] = '{12'h000, 12'h010, 12'h014, 12'h018, 12'h01C,
    12'h020, 12'h024, 12'h030, 12'h034, 12'h100, 12'h110, 12'h120, 12'h130, 12'h104};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_cnt[i] = '0;
    m_cyc = '0; m_en = '0; m_ie = '0; m_ov = '0; m_glob = 0;
    rst_n = 1'b0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; ev_strobe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset image, R2 control contents
    foreach (alist[k]) chk_reg(alist[k], "R1");
    chk_irq("R1 irq");
    reg_addr = 12'h000; #0.2;
    chk("R2 ctrl", reg_rdata, 32'h0000_2000);

    // R3 / R4 set and clear semantics
    tick(1, 12'h010, 32'h8000_0F0F, 4'h0);
    chk_reg(12'h010, "R3 set"); chk_reg(12'h014, "R3 clr view");
    reg_addr = 12'h010; #0.2;
    chk("R4 mask", reg_rdata, 32'h8000_000F);
    tick(1, 12'h014, 32'h0000_0001, 4'h0);
    chk_reg(12'h010, "R3 clr");
    tick(1, 12'h014, 32'h0, 4'h0);
    chk_reg(12'h010, "R3 zero");

    // R12 global off: no counting
    for (int i = 0; i < 3; i++) tick(0, 12'h000, 0, 4'hF);
    chk_reg(12'h120, "R12"); chk_reg(12'h030, "R12 cyc");

    // R5 / R6 counting
    tick(1, 12'h000, 32'h1, 4'h0);
    for (int i = 0; i < 3; i++) tick(0, 12'h000, 0, 4'h5);
    chk_reg(12'h100, "R5 disabled"); chk_reg(12'h120, "R5 count");
    chk_reg(12'h030, "R6");

    // R7 load beats strobe
    tick(1, 12'h110, 32'h1234_5678, 4'h2);
    reg_addr = 12'h110; #0.2;
    chk("R7 load", reg_rdata, 32'h1234_5678);

    // R9 / R10 wrap and interrupt
    tick(1, 12'h130, 32'hFFFF_FFFF, 4'h0);
    tick(1, 12'h018, 32'h0000_0008, 4'h0);
    tick(0, 12'h000, 0, 4'h8);
    chk_reg(12'h130, "R9 cnt"); chk_reg(12'h020, "R9 ovf");
    chk("R10 irq on", {31'b0, irq}, 32'h1);
    tick(1, 12'h024, 32'h0000_0008, 4'h0);
    chk("R10 irq off", {31'b0, irq}, 32'h0);

    // R8 cycle halves and 64-bit wrap
    tick(1, 12'h034, 32'hFFFF_FFFF, 4'h0);
    tick(1, 12'h030, 32'hFFFF_FFFE, 4'h0);
    chk_reg(12'h030, "R8 lo"); chk_reg(12'h034, "R8 hi");
    tick(0, 12'h000, 0, 4'h0);
    tick(0, 12'h000, 0, 4'h0);
    chk_reg(12'h034, "R8 wrap"); chk_reg(12'h020, "R9 cyc ovf");

    // R11 reset-all keeps masks
    tick(1, 12'h000, 32'h3, 4'hF);
    foreach (alist[k]) chk_reg(alist[k], "R11");

    // R12 disable stops counting
    tick(1, 12'h000, 32'h0, 4'h0);
    for (int i = 0; i < 4; i++) tick(0, 12'h000, 0, 4'hF);
    chk_reg(12'h030, "R12 hold"); chk_reg(12'h120, "R12 hold ev");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      bit w;
      a = alist[$urandom_range(13)];
      d = $urandom;
      w = ($urandom_range(9) < 3);
      if (a == 12'h000) d = {30'b0, ($urandom_range(15) == 0), ($urandom_range(3) != 0)};
      else if (a >= 12'h100 || a == 12'h030) d = 32'hFFFF_FFFF - ($urandom_range(7));
      tick(w, a, d, 4'($urandom));
      chk_irq("R10 rand");
      chk_reg(alist[$urandom_range(13)], "R5 rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule